// File: doc/BRIEF.md
# Hidden-Refresh Scheduler for a Pseudo-Static Memory

This block decides when the DRAM core behind a pseudo-static memory gets a row refreshed, so that the asynchronous host bus in front of it never has to know refresh exists. The array is 512K words of 16 bits with upper and lower byte lanes. Only the refresh side is built here. An internal interval timer raises a refresh in the background. Each host access is modelled as a one-cycle grant slot. A refresh that falls due takes the very next slot. The host loses that single slot and nothing more.

A six-bit configuration register holds three settings. The first is a temperature ceiling, which stretches the refresh interval when the ceiling is cooler. The second is the low-power flavour used while the active-low sleep input is held low. The third is how much of the array stays alive in the partial flavour. The register loads a default at reset and can be rewritten in any cycle. After reset, and again after leaving the deep flavour, the block issues one back-to-back sweep over every row before it reports ready.

The controller has four states. WAKE runs the sweep, one row per cycle, and goes to RUN after the last row. RUN is normal operation with timed refresh and host grants. When sleep is asserted, RUN goes to PARTIAL if the select bit is 0, or to DEEP if it is 1. PARTIAL returns to RUN when sleep is released. DEEP returns to WAKE when sleep is released, and the register default is reloaded on the way.

Top module: `psram_refresh_sched`

## Requirements
- R1: `cfg_q` shows the configuration register. Its fields are:
  - bits [1:0] hold the temperature code: 0 for 85 °C, 1 for 45 °C, 2 or 3 for 15 °C.
  - bit [2] selects the low-power flavour: 0 for partial, 1 for deep.
  - bits [5:3] hold the retained extent: 0 for all rows, 1 for a half, 2 for a quarter, 3 for an eighth, 4 to 7 for none.

  Reset loads `CFG_DEFAULT` (0). A cycle with `cfg_we` high loads `cfg_wdata` at the next edge, in any state.
- R2: After reset is released, `ref_gnt` is high for exactly ROWS consecutive cycles, with `ref_row` counting 0 to ROWS-1. `ready` rises in the same cycle as the last of these pulses. `host_gnt` stays low while `ready` is low.
- R3: In normal operation, refresh pulses are spaced BASE_INT, 2·BASE_INT or 4·BASE_INT cycles apart for temperature codes 0, 1 and 2 respectively.
- R4: In normal operation, `ref_row` rises by one on each refresh and wraps from ROWS-1 to 0.
- R5: `ref_gnt` and `host_gnt` are never high together. In normal operation with `host_req` held high, `host_gnt` is low exactly in the cycles where `ref_gnt` is high.
- R6: Driving `sleep_n` low in normal operation with select bit 0 enters partial mode, as follows.
  - `ready` and `host_gnt` go low.
  - Refreshes keep the current interval and restart at row 0.
  - Rows count up to the retained limit minus one and then wrap.
  - An extent of none gives no refresh at all.
  - The extent is captured at entry.
- R7: Releasing `sleep_n` in partial mode returns to normal operation, with `ready` high one cycle later.
- R8: Driving `sleep_n` low in normal operation with select bit 1 enters deep mode. In deep mode no refresh is issued and `ready` stays low.
- R9: Releasing `sleep_n` in deep mode reloads `cfg_q` with the default on the next edge. A full sweep as in R2 follows, before `ready` rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_n | input | 1 | Active-low sleep request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Configuration write value |
| cfg_q | output | 6 | Current configuration |
| host_req | input | 1 | Host wants an access slot |
| host_gnt | output | 1 | Host access slot granted this cycle |
| ref_gnt | output | 1 | Refresh slot granted this cycle |
| ref_row | output | ROW_W | Row refreshed in this slot |
| ready | output | 1 | Normal operation, host accesses served |

## Verification
The bench builds the block with ROWS = 64 and BASE_INT = 6, leaving the configuration default at zero. These values make every row wrap reachable in a few hundred cycles: the full-array wrap, the half (32), eighth (8) and empty retained regions, and the power-up and wake-from-deep sweeps. The interval of 6 keeps the 4x setting at 24 cycles, so all three temperature intervals can be measured pulse to pulse. The deep-mode window covers many of those intervals with no refresh.

// File: rtl/refsch_pkg.sv
package refsch_pkg;

    localparam int CFG_W = 6;

    typedef enum logic [1:0] {
        ST_WAKE,
        ST_RUN,
        ST_PAR,
        ST_DPD
    } state_e;

    // Field order fixes the bit layout seen at cfg_wdata / cfg_q.
    typedef struct packed {
        logic [2:0] extent;  // [5:3]
        logic       deep;    // [2]
        logic [1:0] temp;    // [1:0]
    } cfg_t;

    localparam logic [2:0] EXT_FULL    = 3'd0;
    localparam logic [2:0] EXT_HALF    = 3'd1;
    localparam logic [2:0] EXT_QUARTER = 3'd2;
    localparam logic [2:0] EXT_EIGHTH  = 3'd3;

endpackage

// File: rtl/refsch_cfg.sv
module refsch_cfg #(
    parameter logic [5:0] DEFAULT = 6'h00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [5:0]          wdata,
    input  logic                reload,
    output refsch_pkg::cfg_t    q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= refsch_pkg::cfg_t'(DEFAULT);
        end else if (reload) begin
            q <= refsch_pkg::cfg_t'(DEFAULT);
        end else if (we) begin
            q <= refsch_pkg::cfg_t'(wdata);
        end
    end

endmodule

// File: rtl/refsch_timer.sv
module refsch_timer #(
    parameter int unsigned BASE_INT = 64,
    localparam int unsigned CNT_W   = $clog2(4 * BASE_INT)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       load,
    input  logic [1:0] temp,
    output logic       tick
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload;

    // Cooler ceiling -> longer interval (1x / 2x / 4x).
    always_comb begin
        unique case (temp)
            2'd0:    reload = CNT_W'(BASE_INT - 1);
            2'd1:    reload = CNT_W'(2 * BASE_INT - 1);
            default: reload = CNT_W'(4 * BASE_INT - 1);
        endcase
    end

    assign tick = run && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(BASE_INT - 1);
        end else if (load) begin
            cnt_q <= reload;
        end else if (run) begin
            cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/refsch_rowctr.sv
module refsch_rowctr #(
    parameter int unsigned ROWS  = 2048,
    localparam int unsigned ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    input  logic [ROW_W:0]   limit,
    output logic [ROW_W-1:0] row
);

    logic [ROW_W:0] nxt;

    assign nxt = {1'b0, row} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row <= '0;
        end else if (clr) begin
            row <= '0;
        end else if (adv) begin
            row <= (nxt >= limit) ? '0 : nxt[ROW_W-1:0];
        end
    end

endmodule

// File: rtl/psram_refresh_sched.sv
module psram_refresh_sched #(
    parameter int unsigned  ROWS        = 2048,
    parameter int unsigned  BASE_INT    = 64,
    parameter logic [5:0]   CFG_DEFAULT = 6'h00,
    localparam int unsigned ROW_W       = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_n,
    input  logic             cfg_we,
    input  logic [5:0]       cfg_wdata,
    output logic [5:0]       cfg_q,
    input  logic             host_req,
    output logic             host_gnt,
    output logic             ref_gnt,
    output logic [ROW_W-1:0] ref_row,
    output logic             ready
);

    import refsch_pkg::*;

    localparam logic [ROW_W:0] ALL_ROWS = (ROW_W + 1)'(ROWS);

    state_e           state_q, state_d;
    cfg_t             cfg;
    logic             tick;
    logic [ROW_W-1:0] row_q;
    logic [ROW_W:0]   par_limit_q;
    logic [ROW_W:0]   limit;
    logic             fire;
    logic             enter_par;
    logic             leave_dpd;
    logic             tmr_run;
    logic             tmr_load;

    function automatic logic [ROW_W:0] extent_rows(input logic [2:0] e);
        unique case (e)
            EXT_FULL:    return ALL_ROWS;
            EXT_HALF:    return ALL_ROWS >> 1;
            EXT_QUARTER: return ALL_ROWS >> 2;
            EXT_EIGHTH:  return ALL_ROWS >> 3;
            default:     return '0;
        endcase
    endfunction

    refsch_cfg #(.DEFAULT(CFG_DEFAULT)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .reload (leave_dpd),
        .q      (cfg)
    );

    refsch_timer #(.BASE_INT(BASE_INT)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .load  (tmr_load),
        .temp  (cfg.temp),
        .tick  (tick)
    );

    refsch_rowctr #(.ROWS(ROWS)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (enter_par || leave_dpd),
        .adv   (fire),
        .limit (limit),
        .row   (row_q)
    );

    assign cfg_q     = cfg;
    assign enter_par = (state_q == ST_RUN) && !sleep_n && !cfg.deep;
    assign leave_dpd = (state_q == ST_DPD) && sleep_n;
    assign tmr_run   = (state_q == ST_RUN) || (state_q == ST_PAR);
    assign tmr_load  = (state_q == ST_WAKE) || (state_q == ST_DPD);
    assign limit     = (state_q == ST_PAR) ? par_limit_q : ALL_ROWS;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAKE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and refresh decision
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_WAKE: begin
                fire = 1'b1;
                if (row_q == ROW_W'(ROWS - 1)) state_d = ST_RUN;
            end
            ST_RUN: begin
                fire = tick;
                if (!sleep_n) state_d = cfg.deep ? ST_DPD : ST_PAR;
            end
            ST_PAR: begin
                fire = tick && (par_limit_q != '0);
                if (sleep_n) state_d = ST_RUN;
            end
            ST_DPD: begin
                if (sleep_n) state_d = ST_WAKE;
            end
        endcase
    end

    // Retained extent captured on entry to partial mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_limit_q <= ALL_ROWS;
        end else if (enter_par) begin
            par_limit_q <= extent_rows(cfg.extent);
        end
    end

    // Registered outputs; refresh wins the slot over the host
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_gnt  <= 1'b0;
            ref_row  <= '0;
            host_gnt <= 1'b0;
            ready    <= 1'b0;
        end else begin
            ref_gnt  <= fire;
            ref_row  <= row_q;
            host_gnt <= host_req && (state_q == ST_RUN) && (state_d == ST_RUN) && !fire;
            ready    <= (state_d == ST_RUN);
        end
    end

endmodule

// File: rtl/psram_refresh_sched_chk.sv
module psram_refresh_sched_chk #(
    parameter int unsigned  ROWS        = 2048,
    parameter logic [5:0]   CFG_DEFAULT = 6'h00,
    localparam int unsigned ROW_W       = $clog2(ROWS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ref_gnt,
    input logic                host_gnt,
    input logic                ready,
    input logic [ROW_W-1:0]    ref_row,
    input logic [5:0]          cfg_q,
    input refsch_pkg::state_e  state_q,
    input logic [ROW_W:0]      par_limit_q
);

    import refsch_pkg::*;

    p_grant_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_gnt && host_gnt));

    p_host_needs_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_gnt |-> ready);

    p_sweep_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_gnt && $past(ref_gnt) && !$past(ready))
            |-> (ref_row == ROW_W'($past(ref_row) + 1'b1)));

    p_par_rows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_PAR && ref_gnt) |-> ({1'b0, ref_row} < par_limit_q));

    p_dpd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_DPD && state_q == ST_DPD) |-> (!ref_gnt && !ready));

    p_wake_default_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_DPD && state_q == ST_WAKE) |-> (cfg_q == CFG_DEFAULT));

endmodule

bind psram_refresh_sched psram_refresh_sched_chk #(
    .ROWS        (ROWS),
    .CFG_DEFAULT (CFG_DEFAULT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_gnt     (ref_gnt),
    .host_gnt    (host_gnt),
    .ready       (ready),
    .ref_row     (ref_row),
    .cfg_q       (cfg_q),
    .state_q     (state_q),
    .par_limit_q (par_limit_q)
);

// File: tb/sim_psram_refresh_sched.sv
`timescale 1ns/1ps
module sim_psram_refresh_sched;

    localparam int unsigned ROWS = 64;
    localparam int unsigned BASE = 6;
    localparam int          RW   = $clog2(ROWS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sleep_n = 1'b1;
    logic          cfg_we = 1'b0;
    logic [5:0]    cfg_wdata = '0;
    logic [5:0]    cfg_q;
    logic          host_req = 1'b1;
    logic          host_gnt;
    logic          ref_gnt;
    logic [RW-1:0] ref_row;
    logic          ready;

    int checks   = 0;
    int fails    = 0;
    int excl_bad = 0;

    always #2.5 clk = ~clk;

    psram_refresh_sched #(.ROWS(ROWS), .BASE_INT(BASE), .CFG_DEFAULT(6'h00)) u0 (
        .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .cfg_we(cfg_we),
        .cfg_wdata(cfg_wdata), .cfg_q(cfg_q), .host_req(host_req),
        .host_gnt(host_gnt), .ref_gnt(ref_gnt), .ref_row(ref_row), .ready(ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [5:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
        check(cfg_q == v, "R1 cfg write", int'(cfg_q), int'(v));
    endtask

    // Waits for the next refresh pulse; gap = cycles since the call.
    task automatic wait_ref(output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
            if (host_gnt == ref_gnt) excl_bad++;
        end while (!ref_gnt && gap < 1000);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(ready == 1'b0,    "R2 reset ready",    int'(ready), 0);
        check(ref_gnt == 1'b0,  "R2 reset ref_gnt",  int'(ref_gnt), 0);
        check(host_gnt == 1'b0, "R2 reset host_gnt", int'(host_gnt), 0);
        check(cfg_q == 6'h00,   "R1 reset cfg",      int'(cfg_q), 0);
    endtask

    task automatic t_sweep(input string req);
        int n = 0;
        int bad = 0;
        for (int c = 0; c < int'(ROWS) + 8; c++) begin
            @(negedge clk);
            if (ref_gnt) begin
                if (ref_row != RW'(n)) bad++;
                n++;
            end
            if (!ready && host_gnt) bad++;
            if (ready) break;
        end
        check(n == int'(ROWS), {req, " sweep count"}, n, ROWS);
        check(bad == 0, {req, " sweep order / host held"}, bad, 0);
        check(ready == 1'b1, {req, " ready after sweep"}, int'(ready), 1);
    endtask

    task automatic t_interval(input logic [1:0] temp, input int exp);
        int g;
        write_cfg({3'd0, 1'b0, temp});
        wait_ref(g);
        wait_ref(g);
        wait_ref(g);
        check(g == exp, "R3 interval", g, exp);
        wait_ref(g);
        check(g == exp, "R3 interval repeat", g, exp);
    endtask

    task automatic t_row_wrap;
        int g;
        int prev = -1;
        int bad = 0;
        int wraps = 0;
        for (int i = 0; i < int'(ROWS) + 3; i++) begin
            wait_ref(g);
            if (prev >= 0 && int'(ref_row) != (prev + 1) % int'(ROWS)) bad++;
            if (prev == int'(ROWS) - 1 && ref_row == '0) wraps++;
            prev = int'(ref_row);
        end
        check(bad == 0, "R4 row step", bad, 0);
        check(wraps >= 1, "R4 row wrap", wraps, 1);
        check(excl_bad == 0, "R5 host slot lost only to refresh", excl_bad, 0);
    endtask

    task automatic t_partial(input logic [2:0] ext, input int lim);
        int bad = 0;
        int cnt = 0;
        int exp_row = 0;
        int win = (lim > 0) ? (lim + 4) * int'(BASE) : 8 * int'(BASE);
        write_cfg({ext, 1'b0, 2'd0});
        @(negedge clk); sleep_n = 1'b0;
        @(negedge clk);
        check(ready == 1'b0, "R6 ready low in partial", int'(ready), 0);
        for (int c = 0; c < win; c++) begin
            @(negedge clk);
            if (host_gnt || ready) bad++;
            if (ref_gnt) begin
                if (lim == 0 || int'(ref_row) != exp_row) bad++;
                if (lim > 0) exp_row = (exp_row + 1) % lim;
                cnt++;
            end
        end
        check(bad == 0, "R6 partial rows / quiet host", bad, 0);
        if (lim > 0) check(cnt >= lim + 1, "R6 partial wraps", cnt, lim + 1);
        else         check(cnt == 0, "R6 no refresh for empty extent", cnt, 0);
        @(negedge clk); sleep_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b1, "R7 ready after partial exit", int'(ready), 1);
    endtask

    task automatic t_deep;
        int bad = 0;
        write_cfg({3'd0, 1'b1, 2'd2});
        @(negedge clk); sleep_n = 1'b0;
        @(negedge clk);
        for (int c = 0; c < 40 * int'(BASE); c++) begin
            @(negedge clk);
            if (ref_gnt || ready || host_gnt) bad++;
        end
        check(bad == 0, "R8 deep mode silent", bad, 0);
        @(negedge clk); sleep_n = 1'b1;
        @(negedge clk);
        check(cfg_q == 6'h00, "R9 cfg default on wake", int'(cfg_q), 0);
        check(ref_gnt == 1'b0, "R9 no refresh before sweep", int'(ref_gnt), 0);
        t_sweep("R9");
    endtask

    initial begin
        t_reset;
        @(negedge clk); rst_n = 1'b1;
        t_sweep("R2");
        t_interval(2'd0, BASE);
        t_interval(2'd1, 2 * BASE);
        t_interval(2'd2, 4 * BASE);
        t_interval(2'd0, BASE);
        t_row_wrap;
        t_partial(3'd1, ROWS / 2);
        t_partial(3'd3, ROWS / 8);
        t_partial(3'd5, 0);
        t_deep;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule